// File: doc/BRIEF.md
# Simon-style Feistel round engine with rotated recomputation

This block encrypts one 48-bit block held as two 24-bit words, upper word x and lower word y, by iterating a Feistel round 36 times. Each round replaces (x, y) with (y ^ f(x) ^ k, x), where f(x) = (rotl1(x) & rotl8(x)) ^ rotl2(x) and k is that round's 24-bit key. The key schedule lives outside: the surrounding logic presents one round key at a time on `key_i` with `key_valid_i`, and the engine pulses `key_ack_o` when it has finished with that key.

Faults are caught by time redundancy in the same round logic. Every round is evaluated twice. The first pass uses the operands as they are and keeps the result in a hold register. The second pass rotates both words and the key left by J bits (parameter, default 5), rotates the result right by J, and compares it with the held result. From the second round on, the round input is also compared with the previous round's held output. Any difference sets a sticky error flag. The flag is cleared only by the next accepted start. The ciphertext is still delivered when the flag is set.

Top module: `simon_rr_engine`

## Requirements
- R1: After reset `done_o`, `err_o` and `key_ack_o` are 0 and `ct_o` is zero.
- R2: After `done_o`, `ct_o` equals 36 rounds of (x, y) -> (y ^ f(x) ^ k_i, x) applied to the start value, with f(x) = (rotl1(x) & rotl8(x)) ^ rotl2(x) and k_i the i-th acknowledged key.
- R3: With `key_valid_i` held high, `done_o` is high for exactly one cycle, in the cycle after the 72nd clock edge following the edge that accepted start. Each stall cycle delays it by one.
- R4: `key_ack_o` is high only in the second pass of a round while `key_valid_i` is high. Exactly 36 acknowledges occur per block, and each one advances the round by one.
- R5: A cycle with `key_valid_i` low while busy changes neither `ct_o` nor the round position, and gives no acknowledge.
- R6: In fault-free operation `err_o` stays 0 for every plaintext and key pattern.
- R7: A single-bit flip in the held first-pass result during a second pass sets `err_o`.
- R8: A single-bit flip in the round state at the start of any round after the first sets `err_o`.
- R9: `err_o`, once set, stays set while idle and is cleared by the next accepted start.
- R10: `start_i` while busy is ignored, and the block in progress finishes with its original plaintext.
- R11: `pt_i[47:24]` is word x and `pt_i[23:0]` is word y. The same layout applies to `ct_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a block when idle |
| pt_i | input | 48 | Plaintext {x, y} |
| key_i | input | 24 | Round key for the current round |
| key_valid_i | input | 1 | Round key present; low stalls the engine |
| key_ack_o | output | 1 | Current key consumed; present the next one |
| ct_o | output | 48 | Ciphertext {x, y} |
| done_o | output | 1 | One-cycle completion strobe |
| err_o | output | 1 | Sticky fault flag |

## Verification
Walking-one plaintexts and several dense patterns run against a bench model. A single set bit exposes any misplaced rotation amount or word swap, and the dense values exercise the AND nonlinearity. Stall patterns on the key-valid line separate true round progress from simple cycle counting. Bit-by-bit flips in the hold register during the second pass, and in the state register at round entry, show that each of the two comparisons sees every bit position. Fault-free sweeps show that neither comparison fires on its own.

// File: rtl/simon_rr_pkg.sv
package simon_rr_pkg;
  localparam int WORD_W  = 24;
  localparam int BLOCK_W = 2 * WORD_W;
  localparam int ROUNDS  = 36;
  localparam int ROT_A   = 1;
  localparam int ROT_B   = 8;
  localparam int ROT_C   = 2;
  localparam int ROT_J   = 5;
endpackage

// File: rtl/simon_rr_rot.sv
module simon_rr_rot #(
  parameter int W    = 24,
  parameter int AMT  = 1,
  parameter bit LEFT = 1'b1
) (
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  localparam int S = AMT % W;

  generate
    if (S == 0) begin : g_pass
      assign q_o = d_i;
    end else if (LEFT) begin : g_left
      assign q_o = {d_i[W-S-1:0], d_i[W-1:W-S]};
    end else begin : g_right
      assign q_o = {d_i[S-1:0], d_i[W-1:S]};
    end
  endgenerate
endmodule

// File: rtl/simon_rr_round.sv
module simon_rr_round
  import simon_rr_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic [W-1:0] k_i,
  output logic [W-1:0] x_o,
  output logic [W-1:0] y_o
);
  logic [W-1:0] ra, rb, rc;

  simon_rr_rot #(.W(W), .AMT(ROT_A), .LEFT(1'b1)) u_ra (.d_i(x_i), .q_o(ra));
  simon_rr_rot #(.W(W), .AMT(ROT_B), .LEFT(1'b1)) u_rb (.d_i(x_i), .q_o(rb));
  simon_rr_rot #(.W(W), .AMT(ROT_C), .LEFT(1'b1)) u_rc (.d_i(x_i), .q_o(rc));

  assign x_o = y_i ^ ((ra & rb) ^ rc) ^ k_i;
  assign y_o = x_i;
endmodule

// File: rtl/simon_rr_ctrl.sv
module simon_rr_ctrl
  import simon_rr_pkg::*;
#(
  parameter int N_ROUNDS = ROUNDS
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic key_valid_i,
  output logic load_o,
  output logic step_o,
  output logic pass_o,
  output logic first_o,
  output logic busy_o,
  output logic key_ack_o,
  output logic done_o
);
  localparam int RND_W = (N_ROUNDS > 1) ? $clog2(N_ROUNDS) : 1;
  localparam logic [RND_W-1:0] LAST = RND_W'(N_ROUNDS - 1);

  logic             busy_q, pass_q, done_q;
  logic [RND_W-1:0] rnd_q;
  logic             last;

  assign load_o    = start_i & ~busy_q;
  assign step_o    = busy_q & key_valid_i;
  assign key_ack_o = step_o & pass_q;
  assign last      = key_ack_o & (rnd_q == LAST);
  assign pass_o    = pass_q;
  assign first_o   = (rnd_q == '0);
  assign busy_o    = busy_q;
  assign done_o    = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      pass_q <= 1'b0;
      rnd_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= last;
      if (load_o) begin
        busy_q <= 1'b1;
        pass_q <= 1'b0;
        rnd_q  <= '0;
      end else if (step_o) begin
        pass_q <= ~pass_q;
        if (pass_q) rnd_q <= rnd_q + RND_W'(1);
        if (last) busy_q <= 1'b0;
      end
    end
  end

  a_r3_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  a_r3_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !busy_q);
  a_r4_ack_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_ack_o && rnd_q != LAST) |=> (rnd_q == $past(rnd_q) + RND_W'(1)) && !pass_q);
  a_r5_stall_round: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !key_valid_i) |=> $stable(rnd_q) && $stable(pass_q));
endmodule

// File: rtl/simon_rr_cmp.sv
module simon_rr_cmp #(
  parameter int W = 48
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         re_en_i,
  input  logic [W-1:0] re_a_i,
  input  logic [W-1:0] re_b_i,
  input  logic         ct_en_i,
  input  logic [W-1:0] ct_a_i,
  input  logic [W-1:0] ct_b_i,
  output logic         err_o
);
  logic err_q, hit;

  assign hit   = (re_en_i & (|(re_a_i ^ re_b_i))) | (ct_en_i & (|(ct_a_i ^ ct_b_i)));
  assign err_o = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      err_q <= 1'b0;
    else if (clear_i) err_q <= 1'b0;
    else if (hit)     err_q <= 1'b1;
  end

  a_r9_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && !clear_i) |=> err_q);
endmodule

// File: rtl/simon_rr_engine.sv
module simon_rr_engine
  import simon_rr_pkg::*;
#(
  parameter int W        = WORD_W,
  parameter int N_ROUNDS = ROUNDS,
  parameter int J        = ROT_J
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [2*W-1:0] pt_i,
  input  logic [W-1:0]   key_i,
  input  logic           key_valid_i,
  output logic           key_ack_o,
  output logic [2*W-1:0] ct_o,
  output logic           done_o,
  output logic           err_o
);
  localparam int BW = 2 * W;

  logic          load, step, pass, first, busy;
  logic [BW-1:0] st_q, hold_q, res;
  logic [W-1:0]  sx, sy, jx, jy, jk, ox, oy, ok, rx, ry, bx, by;

  simon_rr_ctrl #(.N_ROUNDS(N_ROUNDS)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .key_valid_i,
    .load_o(load), .step_o(step), .pass_o(pass), .first_o(first),
    .busy_o(busy), .key_ack_o, .done_o
  );

  assign sx = st_q[BW-1:W];
  assign sy = st_q[W-1:0];

  // encode: rotate operands and key for the second pass
  simon_rr_rot #(.W(W), .AMT(J), .LEFT(1'b1)) u_enc_x (.d_i(sx),    .q_o(jx));
  simon_rr_rot #(.W(W), .AMT(J), .LEFT(1'b1)) u_enc_y (.d_i(sy),    .q_o(jy));
  simon_rr_rot #(.W(W), .AMT(J), .LEFT(1'b1)) u_enc_k (.d_i(key_i), .q_o(jk));

  assign ox = pass ? jx : sx;
  assign oy = pass ? jy : sy;
  assign ok = pass ? jk : key_i;

  simon_rr_round #(.W(W)) u_round (
    .x_i(ox), .y_i(oy), .k_i(ok), .x_o(rx), .y_o(ry)
  );

  // decode: undo the rotation on the recomputed result
  simon_rr_rot #(.W(W), .AMT(J), .LEFT(1'b0)) u_dec_x (.d_i(rx), .q_o(bx));
  simon_rr_rot #(.W(W), .AMT(J), .LEFT(1'b0)) u_dec_y (.d_i(ry), .q_o(by));

  assign res = pass ? {bx, by} : {rx, ry};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= '0;
      hold_q <= '0;
    end else if (load) begin
      st_q   <= pt_i;
    end else if (step) begin
      if (pass) st_q   <= res;
      else      hold_q <= res;
    end
  end

  simon_rr_cmp #(.W(BW)) u_cmp (
    .clk_i, .rst_ni,
    .clear_i(load),
    .re_en_i(step & pass),          .re_a_i(res),  .re_b_i(hold_q),
    .ct_en_i(step & ~pass & ~first), .ct_a_i(st_q), .ct_b_i(hold_q),
    .err_o
  );

  assign ct_o = st_q;

  a_r5_stall_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !key_valid_i) |=> $stable(st_q) && $stable(hold_q));
  a_r1_idle_no_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !key_ack_o);
endmodule

// File: tb/simon_rr_engine_tb_top.sv
module simon_rr_engine_tb_top;
  localparam int W  = 24;
  localparam int BW = 48;
  localparam int NR = 36;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [BW-1:0] pt = '0;
  logic [W-1:0]  key = '0;
  logic          kv = 1'b0;
  logic          ack, done, err;
  logic [BW-1:0] ct;

  int n_chk = 0;
  int n_err = 0;
  logic [W-1:0]  rk [NR+1];
  logic [BW-1:0] fval;

  always #5 clk = ~clk;

  simon_rr_engine dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .pt_i(pt), .key_i(key),
    .key_valid_i(kv), .key_ack_o(ack), .ct_o(ct), .done_o(done), .err_o(err)
  );

  function automatic logic [W-1:0] rl(input logic [W-1:0] v, input int s);
    return (v << s) | (v >> (W - s));
  endfunction

  function automatic logic [BW-1:0] model(input logic [BW-1:0] p);
    logic [W-1:0] x, y, t;
    x = p[BW-1:W];
    y = p[W-1:0];
    for (int i = 0; i < NR; i++) begin
      t = y ^ ((rl(x, 1) & rl(x, 8)) ^ rl(x, 2)) ^ rk[i];
      y = x;
      x = t;
    end
    return {x, y};
  endfunction

  task automatic set_keys(input logic [W-1:0] seed);
    logic [W-1:0] s;
    s = seed;
    for (int i = 0; i <= NR; i++) begin
      s = (s << 3) ^ (s >> 5) ^ W'(i * 24'h9e37b) ^ 24'h5a5a5a;
      rk[i] = s;
    end
  endtask

  task automatic chk(input bit ok, input string req, input logic [BW-1:0] act, input logic [BW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // fmode: 0 none, 1 flip hold during pass 2, 2 flip state at round entry
  task automatic run(input logic [BW-1:0] p, input int stall, input int fmode, input int frnd,
                     input int fbit, input bit busy_start, output logic [BW-1:0] res, output logic e);
    int idx, cyc, stalls, acks;
    bit a, forced, stall_chk, quit;
    logic [BW-1:0] prev;
    idx = 0; cyc = 0; stalls = 0; acks = 0; forced = 0; stall_chk = 0; quit = 0;
    @(negedge clk);
    start = 1'b1; pt = p; kv = 1'b0;
    @(negedge clk);
    start = 1'b0;
    chk(err == 1'b0, "R9 cleared by start", BW'(err), '0);
    while (!done && !quit) begin
      kv  = !(stall != 0 && (cyc % 3 == 1));
      key = rk[idx];
      start = busy_start && cyc == 10;
      pt    = busy_start ? ~p : p;
      #1;
      a = ack;
      if (!kv) stalls++;
      if (fmode == 1 && a && idx == frnd) begin
        fval = dut_i.hold_q ^ (BW'(1) << fbit);
        force dut_i.hold_q = fval;
        forced = 1;
      end
      if (fmode == 2 && !a && kv && idx == frnd) begin
        fval = dut_i.st_q ^ (BW'(1) << fbit);
        force dut_i.st_q = fval;
        forced = 1;
      end
      prev = ct;
      @(negedge clk);
      if (forced) begin
        release dut_i.hold_q;
        release dut_i.st_q;
        forced = 0;
      end
      if (!kv && !stall_chk) begin
        stall_chk = 1;
        chk(a == 1'b0, "R5 no ack on stall", BW'(a), '0);
        chk(ct == prev, "R5 state held on stall", ct, prev);
      end
      if (a) acks++;
      if (a) idx++;
      cyc++;
      if (cyc > 2000) begin
        chk(1'b0, "R3 watchdog", BW'(cyc), '0);
        quit = 1;
      end
    end
    start = 1'b0;
    pt = p;
    chk(cyc == 2 * NR + stalls, "R3 done latency", BW'(cyc), BW'(2 * NR + stalls));
    chk(acks == NR, "R4 acknowledge count", BW'(acks), BW'(NR));
    res = ct;
    e = err;
    kv = 1'b0;
    @(negedge clk);
    chk(done == 1'b0, "R3 done single cycle", BW'(done), '0);
  endtask

  logic [BW-1:0] r;
  logic          e;

  initial begin
    #1000000;
    n_chk++;
    n_err++;
    $display("FAIL R3 watchdog expired actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(done == 0 && err == 0 && ack == 0 && ct == '0, "R1 reset state",
        {ct[BW-1:3], done, err, ack}, '0);
    rst_n = 1'b1;

    // R2 R6 walking-one plaintexts
    set_keys(24'h13579b);
    for (int b = 0; b < BW; b++) begin
      run(BW'(1) << b, 0, 0, 0, 0, 0, r, e);
      chk(r == model(BW'(1) << b), "R2 walking one", r, model(BW'(1) << b));
      chk(e == 1'b0, "R6 no false error", BW'(e), '0);
    end

    // R2 R5 R6 dense patterns and key sets, with stalls
    for (int s = 0; s < 6; s++) begin
      logic [BW-1:0] p;
      p = {24'hfedcba, 24'h987654} ^ BW'(s * 48'h0123456789ab);
      set_keys(W'(s * 24'h2468ac + 1));
      run(p, s % 2, 0, 0, 0, 0, r, e);
      chk(r == model(p), "R2 dense pattern", r, model(p));
      chk(e == 1'b0, "R6 no false error dense", BW'(e), '0);
    end

    // R11 word layout: x only and y only
    set_keys(24'h0);
    run({24'h800001, 24'h0}, 0, 0, 0, 0, 0, r, e);
    chk(r == model({24'h800001, 24'h0}), "R11 x word upper", r, model({24'h800001, 24'h0}));
    run({24'h0, 24'h800001}, 0, 0, 0, 0, 0, r, e);
    chk(r == model({24'h0, 24'h800001}), "R11 y word lower", r, model({24'h0, 24'h800001}));

    // R10 start while busy ignored
    set_keys(24'hc0ffee);
    run(48'h0123456789ab, 0, 0, 0, 0, 1, r, e);
    chk(r == model(48'h0123456789ab), "R10 busy start ignored", r, model(48'h0123456789ab));

    // R7 hold flip during second pass, every bit
    for (int b = 0; b < BW; b++) begin
      run(48'h726963_20646e, 0, 1, b % NR, b, 0, r, e);
      chk(e == 1'b1, "R7 hold flip detected", BW'(e), BW'(1));
    end

    // R8 state flip at round entry, every bit
    for (int b = 0; b < BW; b++) begin
      run(48'h726963_20646e, 0, 2, 1 + (b % (NR - 1)), b, 0, r, e);
      chk(e == 1'b1, "R8 state flip detected", BW'(e), BW'(1));
    end

    // R9 sticky while idle, then cleared by a clean block
    repeat (5) @(negedge clk);
    chk(err == 1'b1, "R9 sticky while idle", BW'(err), BW'(1));
    run(48'h1, 0, 0, 0, 0, 0, r, e);
    chk(e == 1'b0, "R9 clean block after fault", BW'(e), '0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule